// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked design read and write an external static RAM that has no clock of its own, organised as 128K locations of one byte each. The host side is a simple request port: the host presents an address, a write flag and write data together with `req` while `ready` is high. The controller answers with a one-clock `done` pulse and, for reads, the captured byte on `rd_data`.

On the memory side the controller drives a pair of chip enables of opposite polarity (one active low, one active high), an active-low output enable, an active-low write enable and the address. The data bus is split into an output byte, an input byte and a drive-enable flag, so the board-level tristate buffer sits outside the block. All memory timing windows are given in nanoseconds as parameters. At elaboration each window is converted to a whole number of clocks by rounding the quotient of nanoseconds and clock period upwards. Each access then runs for a fixed number of cycles.

Every memory pin comes straight from a flop. Reads hold the output enable low and the write enable high. Writes hold the write enable low and the output enable high, so the memory's own drivers stay off while the controller drives the bus. After each read a release gap keeps the bus idle until the memory has let go of it.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous reset the memory is deselected (`mem_en_n`=1, `mem_en`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `done`=0 and `ready`=1.
- R2: A read is accepted on the clock edge where `req`=1, `req_write`=0 and `ready`=1. From that edge `mem_en_n`=0, `mem_en`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 hold, and `mem_addr` stays at the accepted address for the whole read window, whatever the host inputs do afterwards.
- R3: `rd_data` is loaded from `mem_dq_i` on the last edge of the read window. `done` is high for exactly one clock, in the cycle that follows the RD_CYC cycles of the window.
- R4: A write holds `mem_we_n`=0, `mem_oe_n`=1, both enables asserted, and the address and `mem_dq_o` constant for WP_CYC cycles. WP_CYC is the largest of ceil(T_WP_NS/CLK_NS), ceil(T_CW_NS/CLK_NS) and ceil(T_DS_NS/CLK_NS), which is 8 with the defaults. The write ends with `mem_we_n` rising and both enables deasserting on the same edge. `mem_oe_n` and `mem_we_n` are never low together.
- R5: `mem_dq_oe` is high only while `mem_we_n` is low.
- R6: A write's `done` pulse, and the return of `ready`, come WC_CYC edges after acceptance. WC_CYC is the larger of ceil(T_WC_NS/CLK_NS) and WP_CYC+1, which is 9 with the defaults.
- R7: After a read's `done`, `ready` stays low and the memory stays deselected with `mem_oe_n`=1 for TURN_CYC = ceil(T_REL_NS/CLK_NS) cycles (5 with the defaults), counting the `done` cycle. A following write therefore never drives the bus while the memory may still be driving it.
- R8: A `req` raised while `ready` is low is ignored. It starts no access, and no write reaches the memory.
- R9: The read window RD_CYC is the largest of ceil(T_RC_NS/CLK_NS), ceil(T_AA_NS/CLK_NS) and ceil(T_OA_NS/CLK_NS), which is 9 with the defaults. `mem_oe_n` is low for exactly that many cycles per read.
- R10: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller idle, a request may be taken |
| done | output | 1 | One-clock end-of-access strobe |
| rd_data | output | DATA_W | Byte captured by the last read |
| mem_addr | output | ADDR_W | Memory address |
| mem_en_n | output | 1 | Active-low chip enable |
| mem_en | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W | Data seen on the memory bus |

## Verification
The bench contains a memory model with three duties. It returns the inverted byte until the address and output enable have been steady for the access time, so a capture that comes too early returns wrong data. It keeps driving the bus for the release time after a read, so a turnaround that is too short shows up as contention. It measures the write-enable low time and the data-stable time of every write. Directed sequences hit the lowest and highest addresses, repeated reads of one address, write-then-read and read-then-write pairs, and a request raised while the controller is busy. A seeded random mix of reads and writes over a small and a full address range then separates a correct data path from address or data hold faults, which only appear when neighbouring requests differ.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WREC  = 3'd4
  } seq_state_e;

  // Round a nanosecond window up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC   = 9,
  parameter int WP_CYC   = 8,
  parameter int REC_CYC  = 1,
  parameter int TURN_CYC = 5,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_write,
  output logic ready,
  output logic start_rd,
  output logic start_wr,
  output logic rd_last,
  output logic wr_last,
  output logic rec_last
);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC  = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ready_q;
  logic             cnt_zero;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    start_rd = req && !req_write && (state_q == ST_IDLE);
    start_wr = req &&  req_write && (state_q == ST_IDLE);
    rd_last  = (state_q == ST_READ)  && cnt_zero;
    wr_last  = (state_q == ST_WRITE) && cnt_zero;
    rec_last = (state_q == ST_WREC)  && cnt_zero;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start_rd) begin
          state_d = ST_READ;
          cnt_d   = LD_RD;
        end else if (start_wr) begin
          state_d = ST_WRITE;
          cnt_d   = LD_WP;
        end
      end
      ST_READ: begin
        if (cnt_zero) begin
          state_d = ST_TURN;
          cnt_d   = LD_TURN;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_WRITE: begin
        if (cnt_zero) begin
          state_d = ST_WREC;
          cnt_d   = LD_REC;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WREC: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ready_q <= (state_d == ST_IDLE);
    end
  end

  assign ready = ready_q;

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ready_q |-> !(start_rd || start_wr)); // R8

  AST_READ_TO_TURN: assert property (@(posedge clk) disable iff (rst)
    rd_last |=> (state_q == ST_TURN) && !ready_q); // R7

  AST_WRITE_TO_REC: assert property (@(posedge clk) disable iff (rst)
    wr_last |=> (state_q == ST_WREC)); // R6

endmodule

// File: rtl/asram_pins.sv
module asram_pins #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              rd_last,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q;
  logic              en_n_q, en_q, oe_n_q, we_n_q, dq_oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      dq_q    <= '0;
      en_n_q  <= 1'b1;
      en_q    <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else if (start_rd) begin
      addr_q <= req_addr;
      en_n_q <= 1'b0;
      en_q   <= 1'b1;
      oe_n_q <= 1'b0;
    end else if (start_wr) begin
      addr_q  <= req_addr;
      dq_q    <= req_wdata;
      en_n_q  <= 1'b0;
      en_q    <= 1'b1;
      we_n_q  <= 1'b0;
      dq_oe_q <= 1'b1;
    end else if (rd_last) begin
      en_n_q <= 1'b1;
      en_q   <= 1'b0;
      oe_n_q <= 1'b1;
    end else if (wr_last) begin
      en_n_q  <= 1'b1;
      en_q    <= 1'b0;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = dq_q;
  assign mem_en_n  = en_n_q;
  assign mem_en    = en_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_dq_oe = dq_oe_q;

  AST_DRIVE_WE_LOW: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n); // R5

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R4

  AST_EN_PAIRED: assert property (@(posedge clk) disable iff (rst)
    mem_en_n != mem_en); // R2

  AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R2

  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && $stable(mem_addr))); // R4

endmodule

// File: rtl/asram_capture.sv
module asram_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_last,
  input  logic              rec_last,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  logic [DATA_W-1:0] data_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (rd_last) data_q <= mem_dq_i;
      done_q <= rd_last || rec_last;
    end
  end

  assign rd_data = data_q;
  assign done    = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_last) |-> $stable(rd_data)); // R3

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_OA_NS   = 50,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 50,
  parameter int T_CW_NS   = 60,
  parameter int T_DS_NS   = 40,
  parameter int T_REL_NS  = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_CYC = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_NS),
                          imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OA_NS, CLK_NS))));
  localparam int WP_CYC = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS),
                          imax(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS))));
  localparam int WC_CYC   = imax(ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC + 1);
  localparam int REC_CYC  = WC_CYC - WP_CYC;
  localparam int TURN_CYC = imax(1, ns_to_cyc(T_REL_NS, CLK_NS));
  localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic start_rd, start_wr, rd_last, wr_last, rec_last;

  asram_seq #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_write(req_write),
    .ready    (ready),
    .start_rd (start_rd),
    .start_wr (start_wr),
    .rd_last  (rd_last),
    .wr_last  (wr_last),
    .rec_last (rec_last)
  );

  asram_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .start_rd (start_rd),
    .start_wr (start_wr),
    .rd_last  (rd_last),
    .wr_last  (wr_last),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_addr (mem_addr),
    .mem_en_n (mem_en_n),
    .mem_en   (mem_en),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
  );

  asram_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .rd_last (rd_last),
    .rec_last(rec_last),
    .mem_dq_i(mem_dq_i),
    .rd_data (rd_data),
    .done    (done)
  );

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_en_n && !mem_en && mem_oe_n && mem_we_n && !mem_dq_oe)); // R7

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int CLK_NS = 8;
  localparam int AW     = 17;
  localparam int DW     = 8;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = mx(cdiv(70, CLK_NS), cdiv(50, CLK_NS));
  localparam int E_WP   = mx(cdiv(50, CLK_NS), mx(cdiv(60, CLK_NS), cdiv(40, CLK_NS)));
  localparam int E_WC   = mx(cdiv(70, CLK_NS), E_WP + 1);
  localparam int E_TURN = cdiv(35, CLK_NS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready, done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS)) uut (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_en_n(mem_en_n), .mem_en(mem_en),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dflt(input int a);
    return DW'(a) ^ 8'h5A;
  endfunction

  // ---------------- memory model ----------------
  logic [DW-1:0] mdl_mem [int];
  logic [DW-1:0] exp_mem [int];
  bit            mdrive = 1'b0;
  logic [DW-1:0] mq = '0;
  bit            prev_rd = 1'b0, prev_wr = 1'b0;
  int            rd_age = 0, rel = 0, wr_age = 0, d_age = 0;
  logic [AW-1:0] rd_a = '0, wr_a = '0;
  logic [DW-1:0] wr_d = '0;

  function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
    return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : dflt(int'(a));
  endfunction

  assign mem_dq_i = mem_dq_oe ? mem_dq_o : (mdrive ? mq : 8'h00);

  always @(negedge clk) begin
    bit sel, rd_act, wr_act;
    if (rst) begin
      mdrive = 0; prev_rd = 0; prev_wr = 0; rel = 0; rd_age = 0; wr_age = 0;
    end else begin
      sel    = !mem_en_n && mem_en;
      rd_act = sel && !mem_oe_n && mem_we_n;
      wr_act = sel && !mem_we_n;
      if (rd_act) begin
        rd_age = (prev_rd && mem_addr == rd_a) ? rd_age + 1 : 1;
        rd_a   = mem_addr;
        rel    = E_TURN;
        mq     = (rd_age >= E_RD) ? mval(mem_addr) : ~mval(mem_addr);
      end else if (rel > 0) begin
        rel--;
      end
      mdrive  = rd_act || (rel > 0);
      prev_rd = rd_act;
      if (mem_dq_oe && mdrive)
        chk(0, "R7", "bus contention", 1, 0);
      if (mem_dq_oe && mem_we_n)
        chk(0, "R5", "drive with we_n high", 1, 0);
      if (wr_act) begin
        if (prev_wr) begin
          wr_age++;
          if (mem_dq_o == wr_d) d_age++;
          else begin d_age = 1; wr_d = mem_dq_o; end
          if (mem_addr != wr_a) chk(0, "R4", "address moved in write", int'(mem_addr), int'(wr_a));
        end else begin
          wr_age = 1; d_age = 1; wr_d = mem_dq_o; wr_a = mem_addr;
        end
      end else if (prev_wr) begin
        chk(wr_age * CLK_NS >= 60, "R4", "write strobe ns", wr_age * CLK_NS, 60);
        chk(d_age * CLK_NS >= 40, "R4", "data setup ns", d_age * CLK_NS, 40);
        mdl_mem[int'(wr_a)] = wr_d;
      end
      prev_wr = wr_act;
    end
  end

  function automatic logic [DW-1:0] expv(input logic [AW-1:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(int'(a));
  endfunction

  // ---------------- one host access ----------------
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit intrude, input logic [AW-1:0] ia,
                       output logic [DW-1:0] got);
    int lat, pulse, turn;
    bit off;
    got = '0;
    while (!ready) @(negedge clk);
    req = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0; req_addr = AW'($urandom); req_wdata = DW'($urandom);
    if (wr) begin
      chk(!mem_we_n && mem_oe_n && !mem_en_n && mem_en, "R4", "write strobes",
          {mem_en_n, mem_en, mem_oe_n, mem_we_n}, 4'b0110);
      chk(mem_dq_oe && mem_dq_o == d, "R4", "write data", int'(mem_dq_o), int'(d));
    end else begin
      chk(mem_we_n && !mem_oe_n && !mem_en_n && mem_en && !mem_dq_oe, "R2", "read strobes",
          {mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b01010);
    end
    chk(mem_addr == a, wr ? "R4" : "R2", "address", int'(mem_addr), int'(a));
    chk(!ready, "R8", "ready low while busy", int'(ready), 0);
    lat = 1; pulse = 0;
    forever begin
      if (wr ? !mem_we_n : !mem_oe_n) pulse++;
      if (done || lat > 40) break;
      if (intrude && lat == 3) begin
        req = 1; req_write = 1; req_addr = ia; req_wdata = 8'hC3;
      end else begin
        req = 0;
      end
      @(negedge clk);
      lat++;
    end
    req = 0;
    if (wr) begin
      exp_mem[int'(a)] = d;
      chk(lat == E_WC + 1, "R6", "write latency", lat, E_WC + 1);
      chk(pulse == E_WP, "R4", "we_n low cycles", pulse, E_WP);
      chk(ready, "R6", "ready with write done", int'(ready), 1);
      @(negedge clk);
      chk(!done, "R3", "done one clock", int'(done), 0);
    end else begin
      got = rd_data;
      chk(lat == E_RD + 1, "R3", "read latency", lat, E_RD + 1);
      chk(pulse == E_RD, "R9", "oe_n low cycles", pulse, E_RD);
      chk(got == expv(a), "R10", "read data", int'(got), int'(expv(a)));
      turn = 1; off = 1;
      @(negedge clk);
      chk(!done, "R3", "done one clock", int'(done), 0);
      while (!ready && turn < 40) begin
        if (!(mem_en_n && !mem_en && mem_oe_n)) off = 0;
        @(negedge clk);
        turn++;
      end
      chk(turn == E_TURN, "R7", "turnaround cycles", turn, E_TURN);
      chk(off, "R7", "deselected in turnaround", int'(off), 1);
    end
  endtask

  bit finished = 0;

  initial begin
    logic [DW-1:0] g;
    void'($urandom(32'h00C0FFEE));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(mem_en_n && !mem_en && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "idle pins",
        {mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    chk(ready && !done, "R1", "ready after reset", {ready, done}, 2'b10);

    // directed corners
    do_op(1, 17'h00000, 8'h00, 0, '0, g);
    do_op(1, 17'h1FFFF, 8'hFF, 0, '0, g);
    do_op(0, 17'h00000, 8'h00, 0, '0, g);
    do_op(0, 17'h1FFFF, 8'h00, 0, '0, g);
    do_op(0, 17'h1FFFF, 8'h00, 0, '0, g);
    do_op(0, 17'h00123, 8'h00, 0, '0, g);       // never written: default pattern
    do_op(1, 17'h00123, 8'hA5, 0, '0, g);       // read then write
    do_op(0, 17'h00123, 8'h00, 0, '0, g);       // write then read
    // R8: request raised mid-read must not start a write
    do_op(0, 17'h00040, 8'h00, 1, 17'h0ABCD, g);
    do_op(0, 17'h0ABCD, 8'h00, 0, '0, g);
    chk(g == dflt(17'h0ABCD), "R8", "busy request ignored", int'(g), int'(dflt(17'h0ABCD)));

    // seeded random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r1, r2;
      logic [AW-1:0] ra;
      r1 = $urandom; r2 = $urandom;
      ra = r1[0] ? AW'(r2 % 32) : AW'(r2);
      do_op(r1[1], ra, DW'(r1 >> 8), 0, '0, g);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule